// File: doc/BRIEF.md
# Recovered-Clock Loss-of-Lock Fallback Controller

This block decides whether a receive clock-recovery loop may follow the incoming line or must fall back to the local reference clock. It runs entirely in the reference clock domain. Each reference cycle it receives a small count of recovered-clock edges that were synchronized upstream. It totals these edges over a fixed window of reference cycles. At the end of each window it compares the total with the window length. A recovered clock at the nominal rate produces one edge per reference cycle, so the expected total equals the window length.

When the line is followed and the total differs from the window length by the tolerance or more, the block raises its loss-of-lock flag and selects the reference as the clock source. While the reference is in use, the frequency error is taken as zero. After one full window on the reference the flag is released and the line is tried again. The result is a deliberate declare, fall back, clear and retry cycle whenever a line signal is present but off frequency. A no-signal indication from the gain stage holds the block on the reference with the flag raised.

The line-rate mode bit does not take part in the decision, because both clocks scale together in either rate. It is only echoed on a status output.

Top module: `lol_fallback_top`

## Requirements
- R1: After reset, `lolFlag` is 1, `selRef` is 1 (reference selected) and `measCount` is 0.
- R2: At the end of a window spent on the line (`selRef`=0), `measCount` becomes the sum of `lineEdges` over the `WIN_LEN` reference cycles of that window.
- R3: At the end of a window spent on the line, if the edge total differs from `WIN_LEN` by `TOL_CNT` or more in either direction, `lolFlag` and `selRef` become 1.
- R4: At the end of a window spent on the line, if the total is within `TOL_CNT`-1 of `WIN_LEN` and `noSignal` is 0, the block stays on the line with `lolFlag` 0.
- R5: After exactly one full window on the reference, with `noSignal` 0 at the boundary, `lolFlag` and `selRef` both return to 0.
- R6: If `noSignal` is 1 at a window boundary, the block is on the reference with `lolFlag` 1 after that boundary, whichever state it was in before.
- R7: At the end of a window spent on the reference, `measCount` becomes `WIN_LEN`, which stands for zero frequency error.
- R8: `selRef` and `lolFlag` change only in the cycle after a window boundary. A window is `WIN_LEN` reference cycles long, and the first window starts at the first clock edge after reset is released.
- R9: `e3Status` equals `modeE3` as it was one clock earlier, and `modeE3` has no effect on the tolerance decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Local reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineEdges | input | EDGE_W | Recovered-clock edges seen during this reference cycle |
| noSignal | input | 1 | No line energy, reported by the gain control stage |
| modeE3 | input | 1 | Line rate select: 1 = E3, 0 = DS3 |
| lolFlag | output | 1 | Loss-of-lock flag |
| selRef | output | 1 | Clock source select: 1 = reference, 0 = line loop |
| e3Status | output | 1 | Registered copy of the rate mode |
| measCount | output | CNT_W | Edge total latched at the last window boundary |

## Verification
The assertions check on every cycle that the source select holds steady between boundaries. They also check the boundary transitions themselves: a no-signal indication at a boundary forces the fallback, an excursion seen on the line declares loss of lock, a fallback window without a no-signal indication releases the flag, and the count is pinned to the window length while the reference is in use. Other properties can only be shown by the bench's scenarios. These are the exact edge totals, the inclusive tolerance edge in both directions, the full declare, fall back, clear and retry loop over successive windows, and the independence from the rate bit. The bench checks them against a window-level model under random off-frequency totals and random no-signal intervals.

// File: rtl/lol_fallback_pkg.sv
package lol_fallback_pkg;

  // Which clock the recovery loop follows
  typedef enum logic {
    ST_LINE = 1'b0,
    ST_REF  = 1'b1
  } srcState_t;

  // Strobes from the control to the meter
  typedef struct packed {
    logic useRef;   // reference selected: report zero error
  } ctrlStrb_t;

  // Results from the meter to the control
  typedef struct packed {
    logic winEnd;   // last cycle of the current window
    logic excess;   // window total outside tolerance (valid with winEnd)
  } meterStat_t;

endpackage

// File: rtl/lol_freq_meter.sv
module lol_freq_meter
  import lol_fallback_pkg::*;
#(
  parameter int WIN_LEN = 65536,
  parameter int TOL_CNT = 328,
  parameter int EDGE_W  = 2,
  parameter int CNT_W   = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EDGE_W-1:0] lineEdges,
  input  ctrlStrb_t         strb,
  output meterStat_t        stat,
  output logic [CNT_W-1:0]  measCount
);

  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] WIN_C    = CNT_W'(WIN_LEN);
  localparam logic [CNT_W-1:0] TOL_C    = CNT_W'(TOL_CNT);

  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] accum;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] errMag;

  // Window timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 winCnt <= '0;
    else if (winCnt == WIN_LAST) winCnt <= '0;
    else                       winCnt <= winCnt + 1'b1;
  end

  assign stat.winEnd = (winCnt == WIN_LAST);

  // The total includes the edges of the boundary cycle itself
  assign total  = accum + CNT_W'(lineEdges);
  assign errMag = (total >= WIN_C) ? (total - WIN_C) : (WIN_C - total);
  assign stat.excess = (errMag >= TOL_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum     <= '0;
      measCount <= '0;
    end else if (stat.winEnd) begin
      accum     <= '0;
      measCount <= strb.useRef ? WIN_C : total;
    end else begin
      accum     <= total;
    end
  end

  AST_REF_ZERO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (stat.winEnd && strb.useRef) |=> (measCount == WIN_C)); // R7

  AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stat.winEnd |=> !stat.winEnd); // R8

endmodule

// File: rtl/lol_fallback_ctrl.sv
module lol_fallback_ctrl
  import lol_fallback_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       noSignal,
  input  logic       modeE3,
  input  meterStat_t stat,
  output ctrlStrb_t  strb,
  output logic       lolFlag,
  output logic       selRef,
  output logic       e3Status
);

  srcState_t state;

  // Decisions are taken only at window boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_REF;
    end else if (stat.winEnd) begin
      case (state)
        ST_REF:  if (!noSignal) state <= ST_LINE;
        ST_LINE: if (noSignal || stat.excess) state <= ST_REF;
        default: state <= ST_REF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) e3Status <= 1'b0;
    else       e3Status <= modeE3;
  end

  assign selRef      = (state == ST_REF);
  assign lolFlag     = (state == ST_REF);
  assign strb.useRef = (state == ST_REF);

  AST_SEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !stat.winEnd |=> $stable(selRef)); // R8

  AST_NOSIG_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    (stat.winEnd && noSignal) |=> (lolFlag && selRef)); // R6

  AST_EXCESS_DECLARE: assert property (@(posedge clk) disable iff (!rstN)
    (stat.winEnd && stat.excess && !selRef) |=> lolFlag); // R3

  AST_REF_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (stat.winEnd && selRef && !noSignal) |=> (!lolFlag && !selRef)); // R5

endmodule

// File: rtl/lol_fallback_top.sv
module lol_fallback_top
  import lol_fallback_pkg::*;
#(
  parameter int WIN_LEN = 65536,
  parameter int TOL_CNT = 328,
  parameter int EDGE_W  = 2,
  localparam int CNT_W  = $clog2(((2 ** EDGE_W) - 1) * WIN_LEN + 1)
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic [EDGE_W-1:0] lineEdges,
  input  logic              noSignal,
  input  logic              modeE3,
  output logic              lolFlag,
  output logic              selRef,
  output logic              e3Status,
  output logic [CNT_W-1:0]  measCount
);

  ctrlStrb_t  strb;
  meterStat_t stat;

  lol_freq_meter #(
    .WIN_LEN(WIN_LEN),
    .TOL_CNT(TOL_CNT),
    .EDGE_W (EDGE_W),
    .CNT_W  (CNT_W)
  ) uMeter (
    .clk      (refClk),
    .rstN     (rstN),
    .lineEdges(lineEdges),
    .strb     (strb),
    .stat     (stat),
    .measCount(measCount)
  );

  lol_fallback_ctrl uCtrl (
    .clk     (refClk),
    .rstN    (rstN),
    .noSignal(noSignal),
    .modeE3  (modeE3),
    .stat    (stat),
    .strb    (strb),
    .lolFlag (lolFlag),
    .selRef  (selRef),
    .e3Status(e3Status)
  );

endmodule

// File: tb/tb_lol_fallback_top.sv
module tb_lol_fallback_top;

  localparam int W     = 256;
  localparam int TOL   = 8;
  localparam int EW    = 2;
  localparam int CW    = $clog2(((2 ** EW) - 1) * W + 1);

  logic          refClk = 1'b0;
  logic          rstN   = 1'b0;
  logic [EW-1:0] lineEdges = '0;
  logic          noSignal  = 1'b0;
  logic          modeE3    = 1'b0;
  logic          lolFlag, selRef, e3Status;
  logic [CW-1:0] measCount;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model of the window-level behaviour
  bit expRef = 1;
  int expMeas = 0;

  lol_fallback_top #(.WIN_LEN(W), .TOL_CNT(TOL), .EDGE_W(EW)) dut (
    .refClk(refClk), .rstN(rstN), .lineEdges(lineEdges), .noSignal(noSignal),
    .modeE3(modeE3), .lolFlag(lolFlag), .selRef(selRef), .e3Status(e3Status),
    .measCount(measCount)
  );

  always #10 refClk = ~refClk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit outOfTol(input int n);
    int d = (n >= W) ? n - W : W - n;
    return d >= TOL;
  endfunction

  function automatic int edgesAt(input int n, input int i);
    return (n * (i + 1)) / W - (n * i) / W;
  endfunction

  // one full window of n edges; checks mid-window stability and the boundary
  task automatic runWindow(input int n, input bit ns, input bit md, input string req);
    bit wasRef = expRef;
    for (int i = 0; i < W; i++) begin
      lineEdges = EW'(edgesAt(n, i));
      noSignal  = ns;
      modeE3    = md;
      if (i == W / 2) begin
        check("R8 select held mid-window", selRef, wasRef);
        check("R8 lol held mid-window", lolFlag, wasRef);
      end
      @(posedge refClk);
      @(negedge refClk);
    end
    if (wasRef) begin
      expMeas = W;
      expRef  = ns;
    end else begin
      expMeas = n;
      expRef  = ns || outOfTol(n);
    end
    check({req, " lolFlag"}, lolFlag, expRef);
    check({req, " selRef"}, selRef, expRef);
    check({req, " measCount"}, measCount, expMeas);
    check("R9 e3Status", e3Status, md);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge refClk);
    @(negedge refClk);
    check("R1 reset lolFlag", lolFlag, 1);
    check("R1 reset selRef", selRef, 1);
    check("R1 reset measCount", measCount, 0);
    rstN = 1'b1;

    runWindow(W + 40, 1, 0, "R6 no-signal holds fallback, R7");
    runWindow(W + 40, 0, 1, "R5 release after one window, R7");
    runWindow(W + TOL, 0, 0, "R3 fast at tolerance edge, R2");
    runWindow(W, 0, 1, "R5 retry after fallback");
    runWindow(W + TOL - 1, 0, 1, "R4 fast just inside, R2");
    runWindow(W - TOL + 1, 0, 0, "R4 slow just inside, R2");
    runWindow(W - TOL, 0, 1, "R3 slow at tolerance edge, R2");
    runWindow(W, 0, 0, "R5 retry");
    runWindow(W, 1, 0, "R6 no-signal on line");
    runWindow(W, 1, 0, "R6 no-signal kept");
    runWindow(W, 0, 0, "R5 release");
    runWindow(W + 3 * TOL, 0, 0, "R3 far off, declare");
    runWindow(W + 3 * TOL, 0, 0, "R7 zero error on reference");
    runWindow(W + 3 * TOL, 0, 0, "R3 toggle again");

    for (int k = 0; k < 40; k++) begin
      int n  = W - 3 * TOL + int'($urandom % (6 * TOL + 1));
      bit ns = (($urandom % 8) == 0);
      bit md = $urandom % 2;
      runWindow(n, ns, md, "R2 R3 R4 R9 random window");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge refClk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule